// File: doc/BRIEF.md
# Two-Phase CCD Readout Timing Generator

This block is a synchronous sequencer that produces the logic-level clock phases of a full-frame, two-phase CCD: two vertical phases, two horizontal phases and the reset gate of the output sense node. A single-cycle start strobe begins a frame. The vertical clocks then stay low for a programmable exposure time. After that, every line of the frame is moved into the serial register by a fixed three-step vertical sequence. A settling interval follows, and then the fixed number of pixel periods in the line is clocked out.

During the pixel loop, a one-cycle sample strobe tells the external converter when the output level has settled. A region tag marks each sample as dummy, dark reference or photoactive. The reset gate is driven by a free-running pixel timer, so it keeps pulsing at all times. Every pixel loop starts on a boundary of that timer. All timing inputs are in system-clock cycles. The inputs `pix_half`, `rst_width` and `sample_dly` may change only while reset is asserted, and `pix_half` must be at least 1. The other lengths may change only while the block is idle.

Top module: `ccd_readout_timer`

## Requirements
- R1: While reset is asserted and in the idle state after it, the outputs are: `vclk1`=0, `vclk2`=0, `hclk1`=0, `hclk2`=1, `busy`=0, `pix_valid`=0 and `frame_done`=0.
- R2: A start strobe that is sampled while idle makes `busy` rise in the next cycle. Exposure then lasts max(`integ_len`,1) cycles, and both vertical clocks stay low for all of it.
- R3: A start strobe that is sampled while `busy` is high has no effect on any output, and no extra frame follows from it.
- R4: Each line transfer takes three steps of max(`vpulse_len`,1) cycles each, in this order: `vclk2` high alone, then `vclk1` high alone, then both low. `vclk1` and `vclk2` are never high together.
- R5: Outside the pixel loop, `hclk1`=0 and `hclk2`=1, so `vclk1` falls only while `hclk2` is high.
- R6: After each line transfer, a settling interval lasts at least `hsetup_len`+1 cycles. It ends at the first boundary of the pixel timer after that.
- R7: The pixel loop has NPIX periods of 2·`pix_half` cycles each. `hclk1` is high for the first `pix_half` cycles of each period, and `hclk2` is its complement.
- R8: The pixel timer runs freely from reset. `rgate` is high during the first `rst_width` cycles of every period, whatever the sequencer state.
- R9: `pix_valid` is high for one cycle per pixel, at offset `rst_width`+`sample_dly` within the period. It is high only in the pixel loop.
- R10: `pix_region` carries the tag of the current pixel: 0 = dummy, 1 = dark reference, 2 = photoactive. Positions run from 0, in this order: head dummy, head dark, active, tail dark, tail dummy. The default counts are 12/34/2184/34/3.
- R11: A frame has N_LINES line periods. After the last pixel of the last line, `busy` falls and `frame_done` is high for exactly that first idle cycle. A start strobe sampled in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_exp | input | 1 | Start-of-frame strobe |
| integ_len | input | CW | Exposure length in cycles |
| vpulse_len | input | CW | Length of one vertical step in cycles |
| hsetup_len | input | CW | Minimum settling interval before the pixel loop |
| pix_half | input | TW | Half pixel period in cycles |
| rst_width | input | TW | Reset-gate pulse width in cycles |
| sample_dly | input | TW | Delay from end of the reset pulse to the sample strobe |
| vclk1 | output | 1 | Vertical phase 1 |
| vclk2 | output | 1 | Vertical phase 2 |
| hclk1 | output | 1 | Horizontal phase 1 |
| hclk2 | output | 1 | Horizontal phase 2 |
| rgate | output | 1 | Reset gate |
| pix_valid | output | 1 | Sample strobe for the converter |
| pix_region | output | 2 | Region tag of the current pixel |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | End-of-frame pulse |

## Verification
The hardest cases to reach are the ones where the end of the settling interval and the phase of the free-running pixel timer interact. The stimulus chooses settling lengths that are not multiples of the pixel period, so the sequencer has to wait for a period boundary. A second configuration, loaded under reset, uses a zero setup length and a zero step length with a two-cycle pixel period. Start strobes are placed inside an ongoing exposure, in the cycle right after acceptance, and exactly in the `frame_done` cycle. These placements check that a strobe is ignored while busy and accepted back-to-back at the end of a frame.

// File: rtl/ccdtg_pkg.sv
package ccdtg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INTEG,
        ST_VXFER,
        ST_HSETUP,
        ST_PIXELS
    } seq_state_e;

    typedef enum logic [1:0] {
        RG_DUMMY  = 2'd0,
        RG_DARK   = 2'd1,
        RG_ACTIVE = 2'd2
    } region_e;

    typedef struct packed {
        logic v1;
        logic v2;
    } vclk_t;

    // Region of a zero-based serial position, given cumulative region ends
    function automatic region_e region_of(input int unsigned idx,
                                          input int unsigned end_dummy0,
                                          input int unsigned end_dark0,
                                          input int unsigned end_active,
                                          input int unsigned end_dark1);
        if (idx < end_dummy0)      return RG_DUMMY;
        else if (idx < end_dark0)  return RG_DARK;
        else if (idx < end_active) return RG_ACTIVE;
        else if (idx < end_dark1)  return RG_DARK;
        else                       return RG_DUMMY;
    endfunction

    // Vertical drive for each step of a line transfer
    function automatic vclk_t vstep_drive(input logic [1:0] step);
        vclk_t d;
        d = '0;
        case (step)
            2'd0:    d.v2 = 1'b1;
            2'd1:    d.v1 = 1'b1;
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ccdtg_pixel_timer.sv
module ccdtg_pixel_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] pix_half,
    input  logic [TW-1:0] rst_width,
    input  logic [TW-1:0] sample_dly,
    output logic          ph_wrap,
    output logic          h1_phase,
    output logic          rg,
    output logic          sample_pt
);
    localparam int PTW = TW + 1;

    logic [PTW-1:0] ph;
    logic [PTW-1:0] period_m1;

    assign period_m1 = {pix_half, 1'b0} - PTW'(1);
    assign ph_wrap   = (ph == period_m1);
    assign h1_phase  = (ph < {1'b0, pix_half});
    assign rg        = (ph < {1'b0, rst_width});
    assign sample_pt = (ph == (PTW'(rst_width) + PTW'(sample_dly)));

    always_ff @(posedge clk) begin
        if (rst)          ph <= '0;
        else if (ph_wrap) ph <= '0;
        else              ph <= ph + PTW'(1);
    end

    // R7
    ph_in_period_chk: assert property (@(posedge clk) disable iff (rst)
        ph <= period_m1);

    // R8
    rg_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_wrap && rst_width != '0) |=> rg);

endmodule

// File: rtl/ccdtg_frame_seq.sv
module ccdtg_frame_seq
    import ccdtg_pkg::*;
#(
    parameter int N_LINES = 1510,
    parameter int NPIX    = 2267,
    parameter int CW      = 24,
    localparam int LW     = $clog2(N_LINES),
    localparam int PW     = $clog2(NPIX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] integ_len,
    input  logic [CW-1:0] vpulse_len,
    input  logic [CW-1:0] hsetup_len,
    input  logic          ph_wrap,
    output seq_state_e    state,
    output logic [1:0]    step,
    output logic [PW-1:0] pix_idx,
    output logic          frame_done
);
    logic [CW-1:0] cnt;
    logic [LW-1:0] line_idx;
    logic          busy_int;

    function automatic logic cnt_last(input logic [CW-1:0] c, input logic [CW-1:0] len);
        return ({1'b0, c} + (CW+1)'(1)) >= {1'b0, len};
    endfunction

    assign busy_int = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            step       <= '0;
            line_idx   <= '0;
            pix_idx    <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_INTEG;
                        cnt   <= '0;
                    end
                end
                ST_INTEG: begin
                    if (cnt_last(cnt, integ_len)) begin
                        state    <= ST_VXFER;
                        cnt      <= '0;
                        step     <= '0;
                        line_idx <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_VXFER: begin
                    if (cnt_last(cnt, vpulse_len)) begin
                        cnt <= '0;
                        if (step == 2'd2) state <= ST_HSETUP;
                        else              step  <= step + 2'd1;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_HSETUP: begin
                    if (cnt >= hsetup_len && ph_wrap) begin
                        state   <= ST_PIXELS;
                        pix_idx <= '0;
                        cnt     <= '0;
                    end else if (cnt < hsetup_len) begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_PIXELS: begin
                    if (ph_wrap) begin
                        if (pix_idx == PW'(NPIX - 1)) begin
                            if (line_idx == LW'(N_LINES - 1)) begin
                                state      <= ST_IDLE;
                                frame_done <= 1'b1;
                            end else begin
                                line_idx <= line_idx + LW'(1);
                                state    <= ST_VXFER;
                                step     <= '0;
                                cnt      <= '0;
                            end
                        end else begin
                            pix_idx <= pix_idx + PW'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_int) |-> $past(start));

    // R11
    line_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(line_idx) < N_LINES);

    // R10
    pix_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(pix_idx) < NPIX);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (state == ST_IDLE && $past(state) == ST_PIXELS));

endmodule

// File: rtl/ccdtg_region_map.sv
module ccdtg_region_map
    import ccdtg_pkg::*;
#(
    parameter int N_DUMMY0 = 12,
    parameter int N_DARK0  = 34,
    parameter int N_ACTIVE = 2184,
    parameter int N_DARK1  = 34,
    parameter int N_DUMMY1 = 3,
    localparam int NPIX    = N_DUMMY0 + N_DARK0 + N_ACTIVE + N_DARK1 + N_DUMMY1,
    localparam int PW      = $clog2(NPIX)
) (
    input  logic [PW-1:0] pix_idx,
    output region_e       region
);
    localparam int E_DUMMY0 = N_DUMMY0;
    localparam int E_DARK0  = E_DUMMY0 + N_DARK0;
    localparam int E_ACTIVE = E_DARK0 + N_ACTIVE;
    localparam int E_DARK1  = E_ACTIVE + N_DARK1;

    always_comb begin
        region = region_of(32'(pix_idx), E_DUMMY0, E_DARK0, E_ACTIVE, E_DARK1);
    end

endmodule

// File: rtl/ccd_readout_timer.sv
module ccd_readout_timer
    import ccdtg_pkg::*;
#(
    parameter int N_LINES  = 1510,
    parameter int N_DUMMY0 = 12,
    parameter int N_DARK0  = 34,
    parameter int N_ACTIVE = 2184,
    parameter int N_DARK1  = 34,
    parameter int N_DUMMY1 = 3,
    parameter int CW       = 24,
    parameter int TW       = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_exp,
    input  logic [CW-1:0] integ_len,
    input  logic [CW-1:0] vpulse_len,
    input  logic [CW-1:0] hsetup_len,
    input  logic [TW-1:0] pix_half,
    input  logic [TW-1:0] rst_width,
    input  logic [TW-1:0] sample_dly,
    output logic          vclk1,
    output logic          vclk2,
    output logic          hclk1,
    output logic          hclk2,
    output logic          rgate,
    output logic          pix_valid,
    output logic [1:0]    pix_region,
    output logic          busy,
    output logic          frame_done
);
    localparam int NPIX = N_DUMMY0 + N_DARK0 + N_ACTIVE + N_DARK1 + N_DUMMY1;
    localparam int PW   = $clog2(NPIX);

    logic          ph_wrap, h1_phase, sample_pt;
    seq_state_e    state;
    logic [1:0]    step;
    logic [PW-1:0] pix_idx;
    region_e       region;
    vclk_t         vd;

    ccdtg_pixel_timer #(.TW(TW)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .pix_half   (pix_half),
        .rst_width  (rst_width),
        .sample_dly (sample_dly),
        .ph_wrap    (ph_wrap),
        .h1_phase   (h1_phase),
        .rg         (rgate),
        .sample_pt  (sample_pt)
    );

    ccdtg_frame_seq #(.N_LINES(N_LINES), .NPIX(NPIX), .CW(CW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start_exp),
        .integ_len  (integ_len),
        .vpulse_len (vpulse_len),
        .hsetup_len (hsetup_len),
        .ph_wrap    (ph_wrap),
        .state      (state),
        .step       (step),
        .pix_idx    (pix_idx),
        .frame_done (frame_done)
    );

    ccdtg_region_map #(
        .N_DUMMY0 (N_DUMMY0),
        .N_DARK0  (N_DARK0),
        .N_ACTIVE (N_ACTIVE),
        .N_DARK1  (N_DARK1),
        .N_DUMMY1 (N_DUMMY1)
    ) u_region (
        .pix_idx (pix_idx),
        .region  (region)
    );

    always_comb begin
        vd = (state == ST_VXFER) ? vstep_drive(step) : vclk_t'('0);
    end

    assign vclk1      = vd.v1;
    assign vclk2      = vd.v2;
    assign hclk1      = (state == ST_PIXELS) && h1_phase;
    assign hclk2      = !hclk1;
    assign pix_valid  = (state == ST_PIXELS) && sample_pt;
    assign pix_region = region;
    assign busy       = (state != ST_IDLE);

    // R5
    v1_fall_h2_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(vclk1) |-> hclk2);

    // R4
    v_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(vclk1 && vclk2));

    // R4
    v1_after_v2_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vclk1) |-> $past(vclk2));

    // R9
    sample_clear_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (!rgate && busy));

    // R2
    integ_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy || $rose(busy)) |-> (!vclk1 && !vclk2));

endmodule

// File: tb/ccd_readout_timer_test.sv
module ccd_readout_timer_test;

    localparam int LINES = 3;
    localparam int D0 = 2, K0 = 2, AC = 4, K1 = 2, D1 = 1;
    localparam int NPX = D0 + K0 + AC + K1 + D1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_exp = 1'b0;
    logic [23:0] integ_len = '0, vpulse_len = '0, hsetup_len = '0;
    logic [7:0]  pix_half = 8'd1, rst_width = '0, sample_dly = '0;
    logic        vclk1, vclk2, hclk1, hclk2, rgate, pix_valid, busy, frame_done;
    logic [1:0]  pix_region;

    always #2.5 clk = ~clk;

    ccd_readout_timer #(
        .N_LINES(LINES), .N_DUMMY0(D0), .N_DARK0(K0), .N_ACTIVE(AC),
        .N_DARK1(K1), .N_DUMMY1(D1), .CW(24), .TW(8)
    ) uut (
        .clk(clk), .rst(rst), .start_exp(start_exp), .integ_len(integ_len),
        .vpulse_len(vpulse_len), .hsetup_len(hsetup_len), .pix_half(pix_half),
        .rst_width(rst_width), .sample_dly(sample_dly), .vclk1(vclk1),
        .vclk2(vclk2), .hclk1(hclk1), .hclk2(hclk2), .rgate(rgate),
        .pix_valid(pix_valid), .pix_region(pix_region), .busy(busy),
        .frame_done(frame_done)
    );

    int n_cmp = 0, n_bad = 0, n_done = 0;
    bit model_on = 0;
    int m_ph = 0;
    int e_v1 = 0, e_v2 = 0, e_h1 = 0, e_valid = 0, e_busy = 0, e_done = 0, e_region = 0;
    string tag_v = "R1", tag_h = "R5", tag_b = "R1";

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
        end
    endtask

    function automatic int ref_region(input int p);
        if (p < D0) return 0;
        if (p < D0 + K0) return 1;
        if (p < D0 + K0 + AC) return 2;
        if (p < NPX - D1) return 1;
        return 0;
    endfunction

    function automatic int period();
        return 2 * int'(pix_half);
    endfunction

    // free-running pixel timer of the model (R8)
    always @(posedge clk) begin
        if (rst) m_ph <= 0;
        else     m_ph <= (m_ph >= period() - 1) ? 0 : m_ph + 1;
    end

    always @(posedge clk) if (!rst && frame_done) n_done++;

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (model_on && !rst) begin
            chk(tag_v, "vclk1", int'(vclk1), e_v1);
            chk(tag_v, "vclk2", int'(vclk2), e_v2);
            chk(tag_h, "hclk1", int'(hclk1), e_h1);
            chk(tag_h, "hclk2", int'(hclk2), 1 - e_h1);
            chk("R8", "rgate", int'(rgate), (m_ph < int'(rst_width)) ? 1 : 0);
            chk("R9", "pix_valid", int'(pix_valid), e_valid);
            if (e_valid == 1) chk("R10", "pix_region", int'(pix_region), e_region);
            chk(tag_b, "busy", int'(busy), e_busy);
            chk("R11", "frame_done", int'(frame_done), e_done);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_idle(input int d);
        e_v1 = 0; e_v2 = 0; e_h1 = 0; e_valid = 0; e_busy = 0; e_done = d;
        tag_v = "R1"; tag_h = "R5"; tag_b = (d != 0) ? "R11" : "R1";
    endtask

    task automatic model_frame();
        int n;
        // exposure (R2)
        e_busy = 1; e_done = 0; e_v1 = 0; e_v2 = 0; e_h1 = 0; e_valid = 0;
        tag_v = "R2"; tag_b = "R2"; tag_h = "R5";
        n = (integ_len == 0) ? 1 : int'(integ_len);
        repeat (n) tick();
        for (int ln = 0; ln < LINES; ln++) begin
            tag_b = "R11";
            // line transfer (R4), horizontal held (R5)
            n = (vpulse_len == 0) ? 1 : int'(vpulse_len);
            for (int s = 0; s < 3; s++) begin
                tag_v = "R4"; tag_h = "R5";
                e_v1 = (s == 1) ? 1 : 0;
                e_v2 = (s == 0) ? 1 : 0;
                repeat (n) tick();
            end
            // settling (R6)
            e_v1 = 0; e_v2 = 0; tag_h = "R6";
            repeat (int'(hsetup_len)) tick();
            while (m_ph != period() - 1) tick();
            tick();
            // pixel loop (R7, R9, R10)
            tag_h = "R7";
            for (int p = 0; p < NPX; p++) begin
                for (int c = 0; c < period(); c++) begin
                    e_h1 = (c < int'(pix_half)) ? 1 : 0;
                    e_valid = (c == int'(rst_width) + int'(sample_dly)) ? 1 : 0;
                    e_region = ref_region(p);
                    tick();
                end
            end
            e_h1 = 0; e_valid = 0;
        end
    endtask

    task automatic model_frames(input int nf);
        int after;
        after = 0;
        for (int f = 0; f < nf; f++) begin
            do begin
                set_idle(after);
                after = 0;
                tick();
            end while (!start_exp);
            model_frame();
            after = 1;
        end
        set_idle(1);
        tick();
        set_idle(0);
        repeat (4) tick();
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!frame_done) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired at %0t", $time);
        summary();
        $finish;
    end

    initial begin
        // configuration A: period 6, setup not a period multiple
        integ_len = 24'd10; vpulse_len = 24'd3; hsetup_len = 24'd5;
        pix_half = 8'd3; rst_width = 8'd1; sample_dly = 8'd3;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", "vclk1", int'(vclk1), 0);
        chk("R1", "vclk2", int'(vclk2), 0);
        chk("R1", "hclk1", int'(hclk1), 0);
        chk("R1", "hclk2", int'(hclk2), 1);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "pix_valid", int'(pix_valid), 0);
        chk("R1", "frame_done", int'(frame_done), 0);
        rst = 1'b0;
        model_on = 1;
        fork
            model_frames(1);
            begin
                repeat (3) @(negedge clk);
                start_exp = 1'b1;
                @(negedge clk);
                start_exp = 1'b0;
                repeat (40) @(negedge clk);
                // R3: strobe during the frame must be ignored
                start_exp = 1'b1;
                @(negedge clk);
                start_exp = 1'b0;
                wait_done();
            end
        join
        chk("R3", "frame count A", n_done, 1);

        // configuration B: zero lengths, period 2, loaded under reset
        @(negedge clk);
        model_on = 0;
        rst = 1'b1;
        integ_len = 24'd0; vpulse_len = 24'd0; hsetup_len = 24'd0;
        pix_half = 8'd1; rst_width = 8'd1; sample_dly = 8'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_on = 1;
        fork
            model_frames(2);
            begin
                @(negedge clk);
                // R3: second cycle of a two-cycle strobe is ignored
                start_exp = 1'b1;
                repeat (2) @(negedge clk);
                start_exp = 1'b0;
                wait_done();
                // R11: strobe in the frame_done cycle is accepted
                start_exp = 1'b1;
                @(negedge clk);
                start_exp = 1'b0;
                wait_done();
            end
        join
        chk("R3", "frame count B", n_done, 3);
        summary();
        $finish;
    end

endmodule